// File: doc/BRIEF.md
# Decimal Display Zero Blanking Front End

This block sits between a register holding a multi-digit decimal value and the segment drivers of a row of seven-segment digits. It takes one BCD code per digit and the count of digits that lie to the right of the decimal point. It returns one seven-segment pattern per digit, with the zeros that carry no meaning left dark. Leading zeros of the integer part are dark, and so are trailing zeros of the fraction part. With eight digits and four of them fractional, the value 0050.0700 reads as 50.07.

Two ripple chains decide which zeros are dark. The integer chain starts at the most significant digit and walks down toward the point. The fraction chain starts at the least significant digit and walks up toward the point. A per-digit keep mask forces a chosen zero to stay lit, which also stops the chain on that side. Typical uses are the units zero of 0.7346 and the fraction zero of 763.0. A lamp-test input lights every segment of every digit. All patterns are computed combinationally and then captured in one output register.

Top module: `zsup_display`

## Requirements
- R1: While `rst_n` is low, every bit of `seg_out` is 0, whatever the other inputs are.
- R2: A lit digit with code 0 to 9 drives its 7-bit field. Bit 0 is segment a, bit 1 is b, and so on up to bit 6, which is g. The patterns are 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F and 9=0x6F. Digit i occupies bits [7i+6:7i] of `seg_out`, and digit 0 is the least significant.
- R3: Codes 10 to 15 drive an all-dark field, but they count as non-zero, so they stop blanking on their side of the point.
- R4: An integer digit (index at least `point_pos`) is dark when it and every digit above it are zero and none of them is kept.
- R5: A fraction digit (index below `point_pos`) is dark when it and every digit below it are zero and none of them is kept.
- R6: `point_pos` gives the number of fraction digits. A value of 0 means there is no fraction part, and any value of N or more makes every digit a fraction digit.
- R7: A digit whose `keep_mask` bit is set is never dark. Every zero between it and the point on the same side is also never dark.
- R8: An all-zero value with no keep bits and lamp test off drives every field to 0.
- R9: With `lamp_test` high, every bit of `seg_out` is 1.
- R10: `seg_out` reflects the inputs sampled at the previous rising clock edge, so the latency is exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| digits_in | input | 4*NUM_DIGITS | BCD digits; digit 0 sits in bits [3:0] |
| point_pos | input | $clog2(NUM_DIGITS+1) | Number of fraction digits |
| keep_mask | input | NUM_DIGITS | Per-digit force-display bits |
| lamp_test | input | 1 | Lights all segments |
| seg_out | output | 7*NUM_DIGITS | Registered segment patterns, 7 bits per digit |

## Verification
The assertions check the chain structure on every cycle. A dark integer digit implies that the digit above it is also dark in the integer chain. A dark fraction digit implies that the digit below it is also dark in the fraction chain. A dark digit is always a zero that is not kept, a kept decimal digit is lit one cycle later, and lamp test lights everything one cycle later. The assertions cannot show that the right digits are dark, that the decoded patterns are correct, or that the point position splits the digits correctly. Those come from the bench's exhaustive sweep of a four-digit instance over every decimal value and every point position, plus directed keep, non-decimal and lamp cases on an eight-digit instance.

// File: rtl/zsup_pkg.sv
package zsup_pkg;
  localparam int BCD_W = 4;
  localparam int SEG_W = 7;

  // Segment pattern for one digit, bit 0 = segment a ... bit 6 = segment g.
  function automatic logic [SEG_W-1:0] bcd_to_seg(input logic [BCD_W-1:0] code);
    logic [SEG_W-1:0] pat;
    case (code)
      4'd0:    pat = 7'h3F;
      4'd1:    pat = 7'h06;
      4'd2:    pat = 7'h5B;
      4'd3:    pat = 7'h4F;
      4'd4:    pat = 7'h66;
      4'd5:    pat = 7'h6D;
      4'd6:    pat = 7'h7D;
      4'd7:    pat = 7'h07;
      4'd8:    pat = 7'h7F;
      4'd9:    pat = 7'h6F;
      default: pat = 7'h00;
    endcase
    return pat;
  endfunction
endpackage

// File: rtl/zsup_ripple_chain.sv
// One blanking chain. A digit may go dark only if the digit before it in
// the walking order went dark. FROM_LSB selects the walking direction.
module zsup_ripple_chain #(
  parameter int N        = 8,
  parameter bit FROM_LSB = 1'b0
) (
  input  logic [N-1:0] may_blank,
  output logic [N-1:0] blank
);
  generate
    if (FROM_LSB) begin : g_up
      always_comb begin
        logic run;
        run = 1'b1;
        for (int k = 0; k < N; k++) begin
          run      = run & may_blank[k];
          blank[k] = run;
        end
      end
    end else begin : g_down
      always_comb begin
        logic run;
        run = 1'b1;
        for (int k = N - 1; k >= 0; k--) begin
          run      = run & may_blank[k];
          blank[k] = run;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/zsup_digit_out.sv
// Per-digit pattern select: lamp test, then dark, then decoded value.
module zsup_digit_out
  import zsup_pkg::*;
(
  input  logic [BCD_W-1:0] code,
  input  logic             dark,
  input  logic             lamp,
  output logic [SEG_W-1:0] seg
);
  always_comb begin
    if (lamp)      seg = '1;
    else if (dark) seg = '0;
    else           seg = bcd_to_seg(code);
  end
endmodule

// File: rtl/zsup_display.sv
module zsup_display
  import zsup_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  localparam int PW = $clog2(NUM_DIGITS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_DIGITS*BCD_W-1:0] digits_in,
  input  logic [PW-1:0]               point_pos,
  input  logic [NUM_DIGITS-1:0]       keep_mask,
  input  logic                        lamp_test,
  output logic [NUM_DIGITS*SEG_W-1:0] seg_out
);
  localparam int OUT_W = NUM_DIGITS * SEG_W;

  // Named internal events, brought out for the checker.
  logic [NUM_DIGITS-1:0] is_frac;
  logic [NUM_DIGITS-1:0] may_blank;
  logic [NUM_DIGITS-1:0] int_blank;
  logic [NUM_DIGITS-1:0] frac_blank;
  logic [NUM_DIGITS-1:0] digit_blank;
  logic [OUT_W-1:0]      seg_next;
  logic [OUT_W-1:0]      seg_q;

  generate
    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
      assign is_frac[i]     = (PW'(i) < point_pos);
      assign may_blank[i]   = (digits_in[i*BCD_W +: BCD_W] == '0) & ~keep_mask[i];
      assign digit_blank[i] = is_frac[i] ? frac_blank[i] : int_blank[i];

      zsup_digit_out u_digit (
        .code (digits_in[i*BCD_W +: BCD_W]),
        .dark (digit_blank[i]),
        .lamp (lamp_test),
        .seg  (seg_next[i*SEG_W +: SEG_W])
      );
    end
  endgenerate

  // Integer side: walks down from the top digit.
  zsup_ripple_chain #(.N(NUM_DIGITS), .FROM_LSB(1'b0)) u_int_chain (
    .may_blank (may_blank),
    .blank     (int_blank)
  );

  // Fraction side: walks up from digit 0.
  zsup_ripple_chain #(.N(NUM_DIGITS), .FROM_LSB(1'b1)) u_frac_chain (
    .may_blank (may_blank),
    .blank     (frac_blank)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seg_q <= '0;
    else        seg_q <= seg_next;
  end

  assign seg_out = seg_q;
endmodule

// File: rtl/zsup_display_chk.sv
module zsup_display_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N*4-1:0] digits_in,
  input logic [N-1:0]   keep_mask,
  input logic           lamp_test,
  input logic [N*7-1:0] seg_out,
  input logic [N-1:0]   int_blank,
  input logic [N-1:0]   frac_blank,
  input logic [N-1:0]   digit_blank
);
  // R9
  lamp_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_test |=> (seg_out == {(N*7){1'b1}}));

  generate
    for (genvar i = 0; i < N; i++) begin : g_chk
      if (i < N - 1) begin : g_int
        // R4
        int_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
          int_blank[i] |-> int_blank[i+1]);
      end
      if (i > 0) begin : g_frac
        // R5
        frac_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
          frac_blank[i] |-> frac_blank[i-1]);
      end
      // R7
      dark_only_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        digit_blank[i] |-> (digits_in[i*4 +: 4] == 4'd0 && !keep_mask[i]));
      // R7
      kept_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_mask[i] && !lamp_test && digits_in[i*4 +: 4] <= 4'd9)
          |=> (seg_out[i*7 +: 7] != 7'd0));
    end
  endgenerate
endmodule

bind zsup_display zsup_display_chk #(.N(NUM_DIGITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .digits_in   (digits_in),
  .keep_mask   (keep_mask),
  .lamp_test   (lamp_test),
  .seg_out     (seg_out),
  .int_blank   (int_blank),
  .frac_blank  (frac_blank),
  .digit_blank (digit_blank)
);

// File: tb/test_zsup_display.sv
`timescale 1ns/1ps
module test_zsup_display;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lt = 1'b0;
  logic [15:0] d4 = '0;
  logic [2:0]  pp4 = '0;
  logic [3:0]  k4 = '0;
  logic [27:0] s4;
  logic [31:0] d8 = '0;
  logic [3:0]  pp8 = '0;
  logic [7:0]  k8 = '0;
  logic [55:0] s8;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  zsup_display #(.NUM_DIGITS(4)) i_zsup_display (
    .clk(clk), .rst_n(rst_n), .digits_in(d4), .point_pos(pp4),
    .keep_mask(k4), .lamp_test(lt), .seg_out(s4));

  zsup_display #(.NUM_DIGITS(8)) i_zsup_display_8 (
    .clk(clk), .rst_n(rst_n), .digits_in(d8), .point_pos(pp8),
    .keep_mask(k8), .lamp_test(lt), .seg_out(s8));

  function automatic logic [6:0] pat(input logic [3:0] c);
    case (c)
      4'd0: return 7'h3F;  4'd1: return 7'h06;  4'd2: return 7'h5B;
      4'd3: return 7'h4F;  4'd4: return 7'h66;  4'd5: return 7'h6D;
      4'd6: return 7'h7D;  4'd7: return 7'h07;  4'd8: return 7'h7F;
      4'd9: return 7'h6F;  default: return 7'h00;
    endcase
  endfunction

  // A digit is dark when every digit from it out to the end of its side is an unkept zero.
  function automatic logic [55:0] model(input logic [31:0] d, input int pp,
                                        input logic [7:0] k, input logic lamp, input int n);
    logic [55:0] r = '0;
    for (int i = 0; i < n; i++) begin
      logic dark = 1'b1;
      if (i >= pp) begin
        for (int j = i; j < n; j++) if (d[j*4 +: 4] != 0 || k[j]) dark = 1'b0;
      end else begin
        for (int j = 0; j <= i; j++) if (d[j*4 +: 4] != 0 || k[j]) dark = 1'b0;
      end
      r[i*7 +: 7] = lamp ? 7'h7F : (dark ? 7'h00 : pat(d[i*4 +: 4]));
    end
    return r;
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic check4(input string tag);
    logic [55:0] e = model({16'h0, d4}, int'(pp4), {4'h0, k4}, lt, 4);
    checks++;
    if (s4 !== e[27:0]) begin
      fails++;
      $display("FAIL %s n4 d=%h pp=%0d k=%b: got %h exp %h", tag, d4, pp4, k4, s4, e[27:0]);
    end
  endtask

  task automatic check8(input string tag);
    logic [55:0] e = model(d8, int'(pp8), k8, lt, 8);
    checks++;
    if (s8 !== e) begin
      fails++;
      $display("FAIL %s n8 d=%h pp=%0d k=%b: got %h exp %h", tag, d8, pp8, k8, s8, e);
    end
  endtask

  task automatic set8(input logic [31:0] d, input int pp, input logic [7:0] k);
    @(negedge clk);
    d8 = d; pp8 = 4'(pp); k8 = k;
  endtask

  initial begin
    #1_900_000;
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: outputs dark during reset even with lamp test high
    lt = 1'b1; d4 = 16'h1234; d8 = 32'h12345678;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (s4 !== '0 || s8 !== '0) begin
      fails++;
      $display("FAIL R1 reset: got %h/%h exp 0", s4, s8);
    end
    @(negedge clk);
    rst_n = 1'b1; lt = 1'b0;

    // R2 R4 R5 R6 R10: every decimal value at every point position, one cycle latency
    for (int p = 0; p <= 4; p++) begin
      for (int v = 0; v < 10000; v++) begin
        @(negedge clk);
        pp4 = 3'(p);
        d4 = {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
        step();
        check4("R2 R4 R5 R6 R10");
      end
    end

    // R3: non-decimal codes are dark yet stop blanking
    for (int p = 0; p <= 4; p++)
      for (int pos = 0; pos < 4; pos++)
        for (int c = 10; c < 16; c++) begin
          @(negedge clk);
          pp4 = 3'(p); k4 = '0;
          d4 = 16'(c) << (pos * 4);
          step();
          check4("R3");
        end

    // R6: point position beyond the digit count
    for (int p = 5; p < 8; p++) begin
      @(negedge clk);
      pp4 = 3'(p); d4 = 16'h0300;
      step();
      check4("R6");
    end

    // R7: keep mask over several values and points
    for (int km = 0; km < 16; km++)
      for (int p = 0; p <= 4; p++)
        for (int s = 0; s < 4; s++) begin
          @(negedge clk);
          k4 = 4'(km); pp4 = 3'(p);
          d4 = (s == 0) ? 16'h0000 : (s == 1) ? 16'h0050 : (s == 2) ? 16'h7000 : 16'h0103;
          step();
          check4("R7");
        end

    // R8: all zero, no keep, every point position
    for (int p = 0; p <= 4; p++) begin
      @(negedge clk);
      k4 = '0; d4 = '0; pp4 = 3'(p);
      step();
      checks++;
      if (s4 !== '0) begin
        fails++;
        $display("FAIL R8 pp=%0d: got %h exp 0", p, s4);
      end
    end

    // R9: lamp test over blanked and lit values
    @(negedge clk);
    lt = 1'b1; d4 = 16'h0000; d8 = 32'h00500700; pp8 = 4'd4;
    step();
    check4("R9");
    checks++;
    if (s8 !== {56{1'b1}}) begin
      fails++;
      $display("FAIL R9 n8: got %h exp all ones", s8);
    end
    @(negedge clk);
    lt = 1'b0;

    // R4 R5: 0050.0700 reads 50.07
    set8(32'h00500700, 4, 8'h00);
    step();
    checks++;
    if (s8 !== {7'h00, 7'h00, 7'h6D, 7'h3F, 7'h3F, 7'h07, 7'h00, 7'h00}) begin
      fails++;
      $display("FAIL R4 R5 50.07: got %h exp %h", s8,
               {7'h00, 7'h00, 7'h6D, 7'h3F, 7'h3F, 7'h07, 7'h00, 7'h00});
    end

    // R7: 0.7346 with the units zero kept
    set8(32'h00007346, 4, 8'h10);
    step();
    check8("R7");
    checks++;
    if (s8[34:28] !== 7'h3F || s8[41:35] !== 7'h00) begin
      fails++;
      $display("FAIL R7 units zero: got %h exp 3F/00", s8[41:28]);
    end

    // R7: 763.0 with the fraction zero kept
    set8(32'h00007630, 1, 8'h01);
    step();
    check8("R7");
    checks++;
    if (s8[6:0] !== 7'h3F) begin
      fails++;
      $display("FAIL R7 fraction zero: got %h exp 3F", s8[6:0]);
    end

    // R3 R6 R7 R8 on the wide instance
    set8(32'h00A00000, 0, 8'h00); step(); check8("R3");
    set8(32'h00000000, 8, 8'h00); step(); check8("R8");
    set8(32'h00000900, 15, 8'h00); step(); check8("R6");
    set8(32'h00000000, 3, 8'h48); step(); check8("R7");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule